// File: doc/BRIEF.md
# Interrupt Forwarding-Enable Register Bank

This block keeps one forwarding-enable bit for every interrupt ID handled by an interrupt distributor and presents that state to software through two register aliases. A write of ones to the set alias turns on forwarding for the selected IDs. A write of ones to the clear alias turns it off. Zero bits in the write data leave the matching IDs unchanged, and a read of either alias returns the current enable state. The enable state drives a per-interrupt forward-enable vector that goes to the CPU-interface logic. This vector only gates forwarding. Pending and active state are handled elsewhere and are not affected by it.

Each register word holds 32 IDs. Word 0 holds the private IDs and has a separate copy for each requesting PE. A non-secure access cannot see or change the bits of interrupts configured as secure, unless the security-disable control is set. IDs 0 to 15 are permanently enabled. After a clear write, software polls a write-pending status flag until it reads zero. Once the flag is zero, the disable is guaranteed to have taken effect.

Top module: `irq_enable_bank`

## Requirements
- R1: After reset every enable bit of IDs 16 and up is 0, `rwp_o` is 0 and `rdata_o` is 0.
- R2: Interrupt ID m lives in word m/32, bit m%32. On the set alias at byte offset 0x100 + 4*n, a 1 bit enables that ID and a 0 bit changes nothing.
- R3: On the clear alias at byte offset 0x180 + 4*n, a 1 bit disables that ID and a 0 bit changes nothing. Both aliases read back the same enable state. Read data appears on `rdata_o` in the cycle after the read request and holds until the next read.
- R4: Bits for IDs at or above `NUM_IRQ` read as 0, ignore writes, and stay 0 on `fwd_shared_o`.
- R5: When `sec_off_i` is 0, bits whose `grp_secure_i` bit is 1 read as 0 and ignore writes from accesses with `nonsec_i`=1. When `sec_off_i` is 1, non-secure accesses reach them normally.
- R6: Word 0 has an independent copy per PE number 0 to `NUM_PE`-1. An access to word 0 with a PE number of `NUM_PE` or more reads 0 and ignores writes on both aliases.
- R7: IDs 0 to 15 always read as 1 (subject to R5 masking), ignore writes, and are always 1 on `fwd_priv_o`.
- R8: A clear write that turns off at least one enable drives `rwp_o` high from the next cycle for exactly `PEND_DELAY` cycles. A later such write restarts the window. A clear write that turns nothing off leaves `rwp_o` unchanged. Byte offset 0x000 reads `rwp_o` in bit 0 and zero elsewhere.
- R9: Reads of any other offset, including alias words at index `NUM_WORDS` or above, return 0. Writes to such offsets change nothing.
- R10: `fwd_priv_o` (PE p at bits 32p+31..32p) and `fwd_shared_o` (ID m at bit m-32) show a write's effect in the cycle after the write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| nonsec_i | input | 1 | Access is non-secure |
| pe_i | input | PE_W | Number of the requesting PE |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| sec_off_i | input | 1 | Security disabled; non-secure accesses see all bits |
| grp_secure_i | input | NUM_IRQ | Per ID: 1 = interrupt is in a secure group |
| fwd_priv_o | output | NUM_PE*32 | Forward enables of IDs 0..31 for each PE |
| fwd_shared_o | output | (NUM_WORDS-1)*32 | Forward enables of IDs 32 and up |
| rwp_o | output | 1 | A clear write is still propagating |

## Verification
The set and clear aliases are driven with mixed bit patterns, with all-ones and with all-zeros. The mixed patterns show that only the 1 bits act. The all-zeros writes show that 0 bits do nothing, and the all-ones writes expose the masked bits that must not move. The same word is also accessed as a secure access, as a non-secure access, and as a non-secure access with security disabled. Comparing the three read-backs separates the secure masking from the plain enable behaviour. Word 0 is written from two PE numbers in range and from one PE number out of range, which shows the banking and the read-zero/write-ignore rule. Clear writes that do turn off an enable are compared with clear writes that turn off nothing, which pins down both when the write-pending flag rises and how long it stays high.

// File: rtl/irqen_pkg.sv
package irqen_pkg;

    localparam int REG_W     = 32;
    localparam int SGI_COUNT = 16;
    localparam int WIX_W     = 5;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/irqen_decode.sv
module irqen_decode
    import irqen_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [WIX_W-1:0]  widx_o,
    output logic              word_ok_o
);

    localparam logic [ADDR_W-8:0] SET_REGION = (ADDR_W-7)'(2);
    localparam logic [ADDR_W-8:0] CLR_REGION = (ADDR_W-7)'(3);

    logic aligned;
    logic in_range;

    always_comb begin
        aligned   = (addr_i[1:0] == 2'b00);
        widx_o    = addr_i[6:2];
        in_range  = (int'(widx_o) < NUM_WORDS);
        kind_o    = ACC_NONE;
        word_ok_o = 1'b0;
        if (addr_i == '0) begin
            kind_o = ACC_STAT;
        end else if (aligned && in_range && addr_i[ADDR_W-1:7] == SET_REGION) begin
            kind_o    = ACC_SET;
            word_ok_o = 1'b1;
        end else if (aligned && in_range && addr_i[ADDR_W-1:7] == CLR_REGION) begin
            kind_o    = ACC_CLR;
            word_ok_o = 1'b1;
        end
    end

endmodule

// File: rtl/irqen_mask.sv
module irqen_mask
    import irqen_pkg::*;
#(
    parameter int NUM_IRQ   = 80,
    parameter int NUM_WORDS = 3
) (
    input  logic [WIX_W-1:0]   widx_i,
    input  logic               nonsec_i,
    input  logic               sec_off_i,
    input  logic [NUM_IRQ-1:0] grp_secure_i,
    output logic [REG_W-1:0]   vis_o,
    output logic [REG_W-1:0]   wmask_o,
    output logic [REG_W-1:0]   sgi_o
);

    logic [NUM_WORDS*REG_W-1:0] grp_pad;
    logic [REG_W-1:0]           impl_tab [NUM_WORDS];
    logic [REG_W-1:0]           impl_sel;
    logic [REG_W-1:0]           sec_sel;
    logic                       hide_secure;

    // per-word mask of IDs that exist
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_impl
        always_comb begin
            for (int b = 0; b < REG_W; b++) begin
                impl_tab[w][b] = ((w * REG_W + b) < NUM_IRQ);
            end
        end
    end

    always_comb begin
        grp_pad                 = '0;
        grp_pad[NUM_IRQ-1:0]    = grp_secure_i;
        impl_sel                = '0;
        sec_sel                 = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (widx_i == WIX_W'(w)) begin
                impl_sel = impl_tab[w];
                sec_sel  = grp_pad[w*REG_W +: REG_W];
            end
        end
        hide_secure = nonsec_i && !sec_off_i;
        sgi_o       = (widx_i == '0) ? REG_W'((64'd1 << SGI_COUNT) - 64'd1) : '0;
        vis_o       = impl_sel & ~(hide_secure ? sec_sel : '0);
        wmask_o     = vis_o & ~sgi_o;
    end

endmodule

// File: rtl/irqen_rwp.sv
module irqen_rwp #(
    parameter int PEND_DELAY = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_hit_i,
    output logic busy_o
);

    localparam int CW = $clog2(PEND_DELAY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_hit_i) begin
            cnt_d = CW'(PEND_DELAY);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R8: last count with no new clear drops the flag
    a_r8_busy_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CW'(1) && !clr_hit_i) |=> !busy_o);

    // R8: a fresh clear reloads the full window
    a_r8_reload : assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_hit_i |=> (cnt_q == CW'(PEND_DELAY)));

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irqen_pkg::*;
#(
    parameter int NUM_IRQ    = 80,
    parameter int NUM_PE     = 8,
    parameter int PE_W       = 4,
    parameter int PEND_DELAY = 4,
    parameter int ADDR_W     = 12,
    localparam int NUM_WORDS = (NUM_IRQ + REG_W - 1) / REG_W,
    localparam int NSH       = NUM_WORDS - 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [REG_W-1:0]        wdata_i,
    input  logic                    nonsec_i,
    input  logic [PE_W-1:0]         pe_i,
    output logic [REG_W-1:0]        rdata_o,
    input  logic                    sec_off_i,
    input  logic [NUM_IRQ-1:0]      grp_secure_i,
    output logic [NUM_PE*REG_W-1:0] fwd_priv_o,
    output logic [NSH*REG_W-1:0]    fwd_shared_o,
    output logic                    rwp_o
);

    // NUM_IRQ must exceed 32 so that at least one shared word exists
    localparam logic [PE_W-1:0]  PE_LAST  = PE_W'(NUM_PE - 1);
    localparam logic [REG_W-1:0] SGI_ONES = REG_W'((64'd1 << SGI_COUNT) - 64'd1);

    typedef struct packed {
        logic [NUM_PE-1:0][REG_W-1:0] priv;
        logic [NSH-1:0][REG_W-1:0]    shr;
        logic [REG_W-1:0]             rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    acc_kind_e        kind;
    logic [WIX_W-1:0] widx;
    logic             word_ok;
    logic [REG_W-1:0] vis, wmask, sgi;
    logic             busy;
    logic             clr_hit;
    logic             bank_ok;
    logic             mapped;
    logic             word0_sel;
    logic [REG_W-1:0] cur, upd, nxt;

    irqen_decode #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) i_decode (
        .addr_i    (addr_i),
        .kind_o    (kind),
        .widx_o    (widx),
        .word_ok_o (word_ok)
    );

    irqen_mask #(
        .NUM_IRQ   (NUM_IRQ),
        .NUM_WORDS (NUM_WORDS)
    ) i_mask (
        .widx_i       (widx),
        .nonsec_i     (nonsec_i),
        .sec_off_i    (sec_off_i),
        .grp_secure_i (grp_secure_i),
        .vis_o        (vis),
        .wmask_o      (wmask),
        .sgi_o        (sgi)
    );

    irqen_rwp #(
        .PEND_DELAY (PEND_DELAY)
    ) i_rwp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_hit_i (clr_hit),
        .busy_o    (busy)
    );

    always_comb begin
        st_d      = st_q;
        word0_sel = word_ok && (widx == '0);
        bank_ok   = !word0_sel || (pe_i <= PE_LAST);
        mapped    = word_ok && bank_ok;

        cur = '0;
        for (int p = 0; p < NUM_PE; p++) begin
            if (word0_sel && pe_i == PE_W'(p)) cur = st_q.priv[p];
        end
        for (int w = 1; w < NUM_WORDS; w++) begin
            if (widx == WIX_W'(w)) cur = st_q.shr[w-1];
        end

        upd = wdata_i & wmask;
        nxt = (kind == ACC_SET) ? (cur | upd) : (cur & ~upd);

        clr_hit = req_i && we_i && mapped && (kind == ACC_CLR) && ((cur & upd) != '0);

        if (req_i && !we_i) begin
            if (kind == ACC_STAT)  st_d.rdata = {{(REG_W-1){1'b0}}, busy};
            else if (mapped)       st_d.rdata = (cur | sgi) & vis;
            else                   st_d.rdata = '0;
        end

        if (req_i && we_i && mapped) begin
            for (int p = 0; p < NUM_PE; p++) begin
                if (word0_sel && pe_i == PE_W'(p)) st_d.priv[p] = nxt;
            end
            for (int w = 1; w < NUM_WORDS; w++) begin
                if (widx == WIX_W'(w)) st_d.shr[w-1] = nxt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < NUM_PE; p++) begin
            fwd_priv_o[p*REG_W +: REG_W] = st_q.priv[p] | SGI_ONES;
        end
    end
    assign fwd_shared_o = st_q.shr;
    assign rdata_o      = st_q.rdata;
    assign rwp_o        = busy;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    logic [NUM_WORDS*REG_W-1:0] grp_full;
    always_comb begin
        grp_full              = '0;
        grp_full[NUM_IRQ-1:0] = grp_secure_i;
    end

    // R8: a clear that turns something off raises the pending flag
    a_r8_rwp_rise : assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_hit |=> rwp_o);

    // R6: out-of-range PE cannot touch any bank of word 0
    a_r6_pe_oob : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && word_ok && widx == '0 && pe_i > PE_LAST) |=> $stable(fwd_priv_o));

    // R5: non-secure writes never move secure shared bits
    a_r5_ns_guard : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && nonsec_i && !sec_off_i)
        |=> (((fwd_shared_o ^ $past(fwd_shared_o)) & $past(grp_full[NUM_WORDS*REG_W-1:REG_W])) == '0));

    // R9: writes to unmapped offsets leave every enable alone
    a_r9_unmapped : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && !word_ok) |=> ($stable(fwd_priv_o) && $stable(fwd_shared_o)));

    // R4: absent IDs never enable
    if (NUM_WORDS * REG_W > NUM_IRQ) begin : g_unimpl_chk
        a_r4_unimpl_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
            fwd_shared_o[NSH*REG_W-1 : NUM_IRQ-REG_W] == '0);
    end

endmodule

// File: tb/test_irq_enable_bank.sv
module test_irq_enable_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ  = 80;
    localparam int NPE   = 8;
    localparam int DELAY = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0, we = 1'b0, ns = 1'b0, sec_off = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [3:0]        pe = '0;
    logic [NIRQ-1:0]   grp = '0;
    logic [31:0]       rdata;
    logic [NPE*32-1:0] fwd_priv;
    logic [63:0]       fwd_shr;
    logic              rwp;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_enable_bank #(
        .NUM_IRQ    (NIRQ),
        .NUM_PE     (NPE),
        .PE_W       (4),
        .PEND_DELAY (DELAY),
        .ADDR_W     (12)
    ) i_irq_enable_bank (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_i        (req),
        .we_i         (we),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .nonsec_i     (ns),
        .pe_i         (pe),
        .rdata_o      (rdata),
        .sec_off_i    (sec_off),
        .grp_secure_i (grp),
        .fwd_priv_o   (fwd_priv),
        .fwd_shared_o (fwd_shr),
        .rwp_o        (rwp)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all accesses launched at a falling edge, result sampled one falling edge later
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic nsec, input logic [3:0] p);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; ns = nsec; pe = p;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic nsec, input logic [3:0] p, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; ns = nsec; pe = p;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 fwd_shared", {32'h0, fwd_shr[31:0]} | {fwd_shr[63:32], 32'h0}, 64'h0);
        chk("R1 rwp", rwp, 0);
        chk("R1 rdata", rdata, 0);
        chk("R7 fwd_priv pe5", fwd_priv[5*32 +: 32], 32'h0000_FFFF);
        rd(12'h180, 1'b0, 4'd0, v);
        chk("R1 R7 word0 read", v, 32'h0000_FFFF);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(12'h104, 32'hA5A5_0F0F, 1'b0, 4'd0);
        chk("R10 fwd after set", fwd_shr[31:0], 32'hA5A5_0F0F);
        rd(12'h104, 1'b0, 4'd0, v);
        chk("R2 set alias read", v, 32'hA5A5_0F0F);
        rd(12'h184, 1'b0, 4'd0, v);
        chk("R3 clear alias read", v, 32'hA5A5_0F0F);
        wr(12'h184, 32'h0000_000F, 1'b0, 4'd0);
        rd(12'h184, 1'b0, 4'd0, v);
        chk("R3 clear ones", v, 32'hA5A5_0F00);
        wr(12'h184, 32'h0, 1'b0, 4'd0);
        wr(12'h104, 32'h0, 1'b0, 4'd0);
        rd(12'h104, 1'b0, 4'd0, v);
        chk("R2 R3 zero writes no effect", v, 32'hA5A5_0F00);
        // ID 40 -> word 1 bit 8 -> fwd_shared bit 8
        wr(12'h184, 32'hFFFF_FFFF, 1'b0, 4'd0);
        wr(12'h104, 32'h0000_0100, 1'b0, 4'd0);
        chk("R2 R10 ID 40", fwd_shr[31:0], 32'h0000_0100);
        wr(12'h184, 32'hFFFF_FFFF, 1'b0, 4'd0);
        repeat (DELAY + 1) @(negedge clk);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(12'h108, 32'hFFFF_FFFF, 1'b0, 4'd0);
        rd(12'h108, 1'b0, 4'd0, v);
        chk("R4 word2 read", v, 32'h0000_FFFF);
        chk("R4 fwd upper", fwd_shr[63:48], 16'h0);
        wr(12'h188, 32'hFFFF_FFFF, 1'b0, 4'd0);
        repeat (DELAY + 1) @(negedge clk);
    endtask

    task automatic t_security();
        logic [31:0] v;
        grp[47:32] = 16'hFFFF;
        wr(12'h104, 32'hFFFF_FFFF, 1'b1, 4'd0);
        rd(12'h104, 1'b1, 4'd0, v);
        chk("R5 ns read", v, 32'hFFFF_0000);
        rd(12'h104, 1'b0, 4'd0, v);
        chk("R5 secure view after ns set", v, 32'hFFFF_0000);
        wr(12'h104, 32'hFFFF_FFFF, 1'b0, 4'd0);
        wr(12'h184, 32'hFFFF_FFFF, 1'b1, 4'd0);
        rd(12'h184, 1'b0, 4'd0, v);
        chk("R5 ns clear ignored on secure", v, 32'h0000_FFFF);
        sec_off = 1'b1;
        rd(12'h184, 1'b1, 4'd0, v);
        chk("R5 sec off ns read", v, 32'h0000_FFFF);
        wr(12'h184, 32'hFFFF_FFFF, 1'b1, 4'd0);
        chk("R5 sec off ns clear", fwd_shr[31:0], 32'h0);
        sec_off = 1'b0;
        grp = '0;
        repeat (DELAY + 1) @(negedge clk);
    endtask

    task automatic t_bank();
        logic [31:0] v;
        wr(12'h100, 32'hFFFF_0000, 1'b0, 4'd3);
        rd(12'h100, 1'b0, 4'd3, v);
        chk("R6 pe3 read", v, 32'hFFFF_FFFF);
        rd(12'h100, 1'b0, 4'd0, v);
        chk("R6 pe0 separate", v, 32'h0000_FFFF);
        chk("R6 fwd pe3", fwd_priv[3*32 +: 32], 32'hFFFF_FFFF);
        rd(12'h180, 1'b0, 4'd9, v);
        chk("R6 pe9 reads zero", v, 32'h0);
        wr(12'h180, 32'hFFFF_FFFF, 1'b0, 4'd9);
        wr(12'h100, 32'hFFFF_FFFF, 1'b0, 4'd9);
        chk("R6 pe9 writes ignored", {fwd_priv[3*32 +: 32], fwd_priv[0 +: 32]}, {32'hFFFF_FFFF, 32'h0000_FFFF});
        wr(12'h180, 32'hFFFF_FFFF, 1'b0, 4'd3);
        rd(12'h180, 1'b0, 4'd3, v);
        chk("R7 SGIs survive clear", v, 32'h0000_FFFF);
        chk("R7 fwd pe3 SGIs", fwd_priv[3*32 +: 32], 32'h0000_FFFF);
        repeat (DELAY + 1) @(negedge clk);
    endtask

    task automatic t_rwp();
        logic [31:0] v;
        int high;
        wr(12'h104, 32'h0000_0001, 1'b0, 4'd0);
        chk("R8 set keeps rwp low", rwp, 0);
        wr(12'h184, 32'h0000_0001, 1'b0, 4'd0);
        high = 0;
        for (int i = 0; i < DELAY + 3; i++) begin
            if (rwp) high++;
            @(negedge clk);
        end
        chk("R8 rwp window", high, DELAY);
        wr(12'h184, 32'h0000_0001, 1'b0, 4'd0);
        chk("R8 no-op clear", rwp, 0);
        wr(12'h104, 32'h0000_0002, 1'b0, 4'd0);
        wr(12'h184, 32'h0000_0002, 1'b0, 4'd0);
        rd(12'h000, 1'b0, 4'd0, v);
        chk("R8 status read busy", v, 32'h1);
        repeat (DELAY + 1) @(negedge clk);
        rd(12'h000, 1'b0, 4'd0, v);
        chk("R8 status read idle", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h10C, 32'hFFFF_FFFF, 1'b0, 4'd0);
        wr(12'h080, 32'hFFFF_FFFF, 1'b0, 4'd0);
        wr(12'h105, 32'hFFFF_FFFF, 1'b0, 4'd0);
        chk("R9 writes ignored", fwd_shr, 64'h0);
        rd(12'h10C, 1'b0, 4'd0, v);
        chk("R9 beyond last word", v, 32'h0);
        rd(12'h200, 1'b0, 4'd0, v);
        chk("R9 other offset", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_unimpl();
        t_security();
        t_bank();
        t_rwp();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule